// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. A fast input clock stands in for the oscillator signal. An internal prescaler divides that clock by 65 or by 64. Two down-counters sit on the prescaler output. The swallow count `A` keeps the prescaler at 65 for the first `A` prescaler cycles of each output period. The base count `B` sets the total number of prescaler cycles per period. The block therefore emits one single-cycle pulse every N = 64·B + A input cycles, and that pulse feeds a phase detector.

The divide setting is written through a strobe together with the `A` and `B` values. Each write is checked for legality as it arrives. A legal setting is placed in a shadow register, and the counters copy it only when the current output period ends, so a period that has already started is never cut short or stretched. An illegal setting raises an error flag, and the divider keeps running on the last legal setting. For example, a target of N = 16672 is written as B = 260 and A = 32.

Top module: `dual_mod_divider`

## Requirements
- R1: The number of input clock cycles between consecutive rising cycles of `div_pulse` is exactly 64·B + A for the setting in force.
- R2: Within each output period `mod65` is high for exactly the first 65·A input cycles (A prescaler cycles of 65), then low for the remaining (B−A)·64 cycles.
- R3: `div_pulse` is high for exactly one input cycle per output period.
- R4: A write (`cfg_we` high for one cycle) is accepted when B ≥ 3, A < B and A < 64; `cfg_err` reads 0 in the cycle after an accepted write.
- R5: A write with B < 3, or A ≥ B, or A ≥ 64 sets `cfg_err` to 1 in the next cycle, and the divider keeps the previous setting: later periods keep the old length.
- R6: An accepted setting takes effect with the first output period that starts after the write; the period in progress at the time of the write keeps its old length.
- R7: While `rst` (synchronous, active high) is asserted, `div_pulse` is 0, `cfg_err` is 0 and `mod65` is 1. After release the setting is A = 1, B = 3, so the first pulse appears 193 cycles after the first clock edge out of reset.
- R8: With A = 0 the prescaler never swallows: `mod65` stays low for the whole period and the period is 64·B cycles.
- R9: The boundary setting B = A + 1 is accepted and divides by 64·B + A (B = 3, A = 2 gives 194).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (oscillator stand-in) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-cycle strobe that submits a new setting |
| cfg_a | input | 7 | Swallow count A |
| cfg_b | input | 11 | Base count B |
| div_pulse | output | 1 | One-cycle pulse per output period |
| mod65 | output | 1 | High while the prescaler divides by 65 |
| cfg_err | output | 1 | Last submitted setting was illegal |

## Verification
The hardest case to reach is a write that lands in the middle of a period: it must leave that period alone and change only the next one. The stimulus therefore times every write to the cycle just after a pulse, so that each write falls early in a known period. Expected period lengths and swallow-cycle counts are queued per period and compared when each pulse arrives. A run of illegal settings is placed between legal ones, so that a setting which leaked through would show up as a wrong period length.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    localparam int PRE_MOD = 64;
    localparam int A_W     = 7;
    localparam int B_W     = 11;
    localparam int CNT_W   = $clog2(PRE_MOD + 1);
    localparam int B_MIN   = 3;

    typedef struct packed {
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } div_cfg_t;

    // legal when base count is large enough and exceeds the swallow count
    function automatic logic cfg_ok(div_cfg_t c);
        return (c.b >= B_W'(B_MIN)) && (B_W'(c.a) < c.b) && (c.a < A_W'(PRE_MOD));
    endfunction
endpackage

// File: rtl/dmd_cfg_shadow.sv
module dmd_cfg_shadow
    import dmd_pkg::*;
#(
    parameter int DEF_A = 1,
    parameter int DEF_B = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  div_cfg_t wr_cfg,
    output div_cfg_t stage,
    output logic     err
);
    localparam div_cfg_t RESET_CFG = '{b: B_W'(DEF_B), a: A_W'(DEF_A)};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= RESET_CFG;
            err   <= 1'b0;
        end else if (wr_en) begin
            if (cfg_ok(wr_cfg)) begin
                stage <= wr_cfg;
                err   <= 1'b0;
            end else begin
                err   <= 1'b1;
            end
        end
    end

    AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cfg_ok(stage)); // R4
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_ok(wr_cfg)) |=> (stage == $past(stage) && err)); // R5
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler
    import dmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic swallow,
    output logic pre_tc
);
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] last;

    assign last   = swallow ? CNT_W'(PRE_MOD) : CNT_W'(PRE_MOD - 1);
    assign pre_tc = (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst)         pcnt <= '0;
        else if (pre_tc) pcnt <= '0;
        else             pcnt <= pcnt + CNT_W'(1);
    end

    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pcnt <= CNT_W'(PRE_MOD)); // R2
endmodule

// File: rtl/dmd_swallow_ctr.sv
module dmd_swallow_ctr
    import dmd_pkg::*;
#(
    parameter int DEF_A = 1,
    parameter int DEF_B = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pre_tc,
    input  div_cfg_t load_cfg,
    output logic     swallow,
    output logic     div_pulse
);
    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;
    logic           last_cycle;

    assign swallow    = (a_rem != '0);
    assign last_cycle = pre_tc && (b_rem == B_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rem     <= A_W'(DEF_A);
            b_rem     <= B_W'(DEF_B);
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= last_cycle;
            if (last_cycle) begin
                a_rem <= load_cfg.a;
                b_rem <= load_cfg.b;
            end else if (pre_tc) begin
                b_rem <= b_rem - B_W'(1);
                if (swallow) a_rem <= a_rem - A_W'(1);
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R3
    AST_BASE_STAYS: assert property (@(posedge clk) disable iff (rst)
        !swallow |=> (!swallow || div_pulse)); // R2
    AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (rst)
        last_cycle |-> (a_rem == '0)); // R1
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider
    import dmd_pkg::*;
#(
    parameter int DEF_A = 1,
    parameter int DEF_B = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    output logic           div_pulse,
    output logic           mod65,
    output logic           cfg_err
);
    div_cfg_t wr_cfg;
    div_cfg_t stage;
    logic     swallow;
    logic     pre_tc;

    assign wr_cfg = '{b: cfg_b, a: cfg_a};
    assign mod65  = swallow;

    dmd_cfg_shadow #(.DEF_A(DEF_A), .DEF_B(DEF_B)) u_shadow (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_cfg(wr_cfg),
        .stage(stage), .err(cfg_err)
    );

    dmd_prescaler u_pre (
        .clk(clk), .rst(rst), .swallow(swallow), .pre_tc(pre_tc)
    );

    dmd_swallow_ctr #(.DEF_A(DEF_A), .DEF_B(DEF_B)) u_ctr (
        .clk(clk), .rst(rst), .pre_tc(pre_tc), .load_cfg(stage),
        .swallow(swallow), .div_pulse(div_pulse)
    );
endmodule

// File: tb/test_dual_mod_divider.sv
`timescale 1ns/1ps
module test_dual_mod_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_a = '0;
    logic [10:0] cfg_b = '0;
    logic        div_pulse, mod65, cfg_err;

    always #4 clk = ~clk;

    dual_mod_divider i_dual_mod_divider (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .div_pulse(div_pulse), .mod65(mod65), .cfg_err(cfg_err)
    );

    typedef struct {
        int    n;
        int    sw;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   model_a = 1;
    int   model_b = 3;
    int   cnt = 1;
    int   hcnt = 0;
    bit   prev_pulse = 0;
    bit   done = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_period(string tag);
        exp_t e;
        e.n   = 64 * model_b + model_a;
        e.sw  = 65 * model_a;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    // write at the start of a period; that period is tagged ptag
    task automatic write_cfg(int a, int b, string ptag);
        bit legal;
        wait_pulse();
        push_period(ptag);
        #1;
        cfg_a  = 7'(a);
        cfg_b  = 11'(b);
        cfg_we = 1'b1;
        @(negedge clk);
        #1 cfg_we = 1'b0;
        legal = (b >= 3) && (a < b) && (a < 64);
        if (legal) begin
            check(cfg_err == 1'b0, "R4", "error flag after legal write", int'(cfg_err), 0);
            model_a = a;
            model_b = b;
        end else begin
            check(cfg_err == 1'b1, "R5", "error flag after illegal write", int'(cfg_err), 1);
        end
    endtask

    // monitor: measures each period and compares against the queue
    always @(negedge clk) begin
        if (rst) begin
            cnt  = 1;
            hcnt = int'(mod65);
            prev_pulse = 1'b0;
        end else begin
            if (div_pulse) begin
                check(!prev_pulse, "R3", "pulse width", 2, 1);
                if (q.size() == 0) begin
                    check(1'b0, "R1", "unexpected pulse after cycles", cnt, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cnt == e.n, e.tag, "period length", cnt, e.n);
                    check(hcnt == e.sw, "R2", "divide-by-65 cycles", hcnt, e.sw);
                end
                cnt  = 1;
                hcnt = int'(mod65);
            end else begin
                cnt++;
                hcnt += int'(mod65);
            end
            prev_pulse = div_pulse;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R7", "pulse in reset", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R7", "error in reset", int'(cfg_err), 0);
        check(mod65 == 1'b1, "R7", "mod65 in reset", int'(mod65), 1);
        push_period("R7");
        #1 rst = 1'b0;

        write_cfg(0, 5, "R7");       // period keeps default 193
        write_cfg(2, 3, "R8");       // A=0 period, 320
        write_cfg(3, 4, "R9");       // B=A+1 period, 194
        write_cfg(0, 2, "R1");       // 259; B<3 rejected
        write_cfg(5, 5, "R5");       // A==B rejected
        write_cfg(64, 100, "R5");    // A>=64 rejected
        write_cfg(127, 2047, "R5");  // A>=64 rejected
        write_cfg(32, 260, "R5");    // still 259; then 16672 accepted
        write_cfg(12, 99, "R6");     // in-progress 16672 unaffected
        wait_pulse();
        push_period("R6");           // 6348 now in force
        wait_pulse();
        @(negedge clk);
        check(q.size() == 0, "R1", "periods left unchecked", q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 150000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule